// File: doc/BRIEF.md
# External Interrupt Controller Register Bank

This block collects up to 32 external interrupt pins into one interrupt request for a processor. Each pin first passes through a synchroniser. It is then judged by its own mode: edge or level detection, active high or active low. An edge that matches the chosen polarity is held in a pending latch until software acknowledges it. A level channel reports the live state of its synchronised pin. Software can also force a channel pending by setting that channel's soft-request bit.

Software reaches the block through a simple memory-mapped port. The mask, mode, polarity and soft-request settings each have a read address, a set alias and a clear alias. A write to an alias changes only the bits written as one, so one driver can update its own channel without a read-modify-write sequence. A status word shows every channel that is both active and unmasked. The single interrupt output is high whenever any status bit is high.

Top module: `extirq_bank`

## Requirements
- R1: After reset the mask reads all ones, the mode, polarity and soft-request registers read zero, status reads zero and `irq_o` is low.
- R2: The mask reads at 0x080. Writing ones to 0x0C0 masks those channels and writing ones to 0x100 unmasks them. Bits written as zero keep their value. A mask bit of 1 disables its channel.
- R3: The mode register reads at 0x140, with set alias 0x180 and clear alias 0x1C0. A bit of 1 selects level detection and a bit of 0 selects edge detection.
- R4: The polarity register reads at 0x300, with set alias 0x340 and clear alias 0x380. A bit of 1 selects active-high level or rising edge. A bit of 0 selects active-low level or falling edge.
- R5: The soft-request register reads at 0x200, with set alias 0x240 and clear alias 0x280. A set bit makes its channel active whatever the pin does.
- R6: In an edge channel, a matching pin transition sets a pending latch. The latch is visible in status when the pin has been stable for three clock edges after the transition. It stays set after the pin returns.
- R7: Writing ones to 0x040 clears the pending latches of those channels. The write has no effect on level channels or soft requests. If an edge is detected in the same cycle as the acknowledge, the latch stays set.
- R8: In a level channel, status follows the synchronised pin at the chosen polarity, two clock edges after the pin changes.
- R9: Status reads at 0x000. Bit n is channel n, and it shows the channel's active state AND NOT its mask bit. Masking a channel does not stop its pending latch from being set, so the latch shows up when the channel is later unmasked.
- R10: `irq_o` is the OR of all status bits.
- R11: Read data is registered and is valid in the cycle after `rd_en`. Reads of unmapped addresses, of 0x040 and of the set and clear aliases return zero. Writes to read-only addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NCH | Asynchronous external interrupt pins |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is an acknowledge that lands in the same cycle in which a new edge is detected on the same channel. If the design gets this wrong, an interrupt is lost without any sign. The bench first latches a pending edge on the channel. It then raises the pin at a known falling clock edge and counts the two synchroniser stages. It issues the acknowledge write so that it is captured on the exact edge where the pending latch is set, and then reads status to check that the latch survived. A long random phase follows. It mixes pin toggles with alias writes to every register and compares every clock against a behavioural model, which also covers mode switches while a latch is pending.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
   localparam int unsigned MAP_W = 12;
   localparam logic [MAP_W-1:0] A_STATUS   = 12'h000;
   localparam logic [MAP_W-1:0] A_ACK      = 12'h040;
   localparam logic [MAP_W-1:0] A_MASK     = 12'h080;
   localparam logic [MAP_W-1:0] A_MASK_SET = 12'h0C0;
   localparam logic [MAP_W-1:0] A_MASK_CLR = 12'h100;
   localparam logic [MAP_W-1:0] A_MODE     = 12'h140;
   localparam logic [MAP_W-1:0] A_MODE_SET = 12'h180;
   localparam logic [MAP_W-1:0] A_MODE_CLR = 12'h1C0;
   localparam logic [MAP_W-1:0] A_SOFT     = 12'h200;
   localparam logic [MAP_W-1:0] A_SOFT_SET = 12'h240;
   localparam logic [MAP_W-1:0] A_SOFT_CLR = 12'h280;
   localparam logic [MAP_W-1:0] A_POL      = 12'h300;
   localparam logic [MAP_W-1:0] A_POL_SET  = 12'h340;
   localparam logic [MAP_W-1:0] A_POL_CLR  = 12'h380;

   typedef struct packed {
      logic ack;
      logic mask_set;
      logic mask_clr;
      logic mode_set;
      logic mode_clr;
      logic soft_set;
      logic soft_clr;
      logic pol_set;
      logic pol_clr;
   } wr_sel_t;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o,
   output logic [W-1:0] prev_o
);
   logic [W-1:0] chain_q [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("extirq_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_o <= '0;
      else        prev_o <= chain_q[STAGES-1];
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/extirq_w1sc_reg.sv
module extirq_w1sc_reg #(
   parameter int unsigned W     = 32,
   parameter logic [W-1:0] RST  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic         clr_en,
   input  logic [W-1:0] bits_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= RST;
      else if (set_en) q_o <= q_o | bits_i;
      else if (clr_en) q_o <= q_o & ~bits_i;
   end
endmodule

// File: rtl/extirq_detect.sv
module extirq_detect #(
   parameter int unsigned NCH = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] now_i,
   input  logic [NCH-1:0] prev_i,
   input  logic [NCH-1:0] mode_i,
   input  logic [NCH-1:0] pol_i,
   input  logic [NCH-1:0] soft_i,
   input  logic [NCH-1:0] mask_i,
   input  logic           ack_en,
   input  logic [NCH-1:0] ack_bits,
   output logic [NCH-1:0] hit_o,
   output logic [NCH-1:0] pend_o,
   output logic [NCH-1:0] status_o
);
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic rise, fall, active, level_on;

      assign rise     = now_i[c] & ~prev_i[c];
      assign fall     = ~now_i[c] & prev_i[c];
      assign hit_o[c] = ~mode_i[c] & (pol_i[c] ? rise : fall);
      assign level_on = pol_i[c] ? now_i[c] : ~now_i[c];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       pend_o[c] <= 1'b0;
         else if (hit_o[c])                pend_o[c] <= 1'b1;
         else if (ack_en && ack_bits[c])   pend_o[c] <= 1'b0;
      end

      assign active      = (mode_i[c] ? level_on : pend_o[c]) | soft_i[c];
      assign status_o[c] = active & ~mask_i[c];
   end
endmodule

// File: rtl/extirq_bank.sv
module extirq_bank #(
   parameter int unsigned NCH         = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    pin_i,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq_o
);
   import extirq_pkg::*;

   localparam int unsigned PAD = DATA_W - NCH;

   if (NCH < 1 || NCH > DATA_W) begin : g_bad_nch
      $error("extirq_bank: NCH must be 1..DATA_W");
   end
   if (ADDR_W < MAP_W) begin : g_bad_addr
      $error("extirq_bank: ADDR_W too narrow for the register map");
   end

   logic [NCH-1:0] pin_now, pin_prev;
   logic [NCH-1:0] mask_w, mode_w, pol_w, soft_w;
   logic [NCH-1:0] hit_w, pend_w, status_w;
   logic [NCH-1:0] wbits;
   wr_sel_t        wsel;

   assign wbits = wdata[NCH-1:0];

   function automatic logic at(input logic [ADDR_W-1:0] a, input logic [MAP_W-1:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   always_comb begin
      wsel          = '0;
      wsel.ack      = wr_en && at(addr, A_ACK);
      wsel.mask_set = wr_en && at(addr, A_MASK_SET);
      wsel.mask_clr = wr_en && at(addr, A_MASK_CLR);
      wsel.mode_set = wr_en && at(addr, A_MODE_SET);
      wsel.mode_clr = wr_en && at(addr, A_MODE_CLR);
      wsel.soft_set = wr_en && at(addr, A_SOFT_SET);
      wsel.soft_clr = wr_en && at(addr, A_SOFT_CLR);
      wsel.pol_set  = wr_en && at(addr, A_POL_SET);
      wsel.pol_clr  = wr_en && at(addr, A_POL_CLR);
   end

   extirq_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(pin_now), .prev_o(pin_prev)
   );

   extirq_w1sc_reg #(.W(NCH), .RST({NCH{1'b1}})) u_mask (
      .clk(clk), .rst_n(rst_n), .set_en(wsel.mask_set), .clr_en(wsel.mask_clr),
      .bits_i(wbits), .q_o(mask_w)
   );
   extirq_w1sc_reg #(.W(NCH), .RST('0)) u_mode (
      .clk(clk), .rst_n(rst_n), .set_en(wsel.mode_set), .clr_en(wsel.mode_clr),
      .bits_i(wbits), .q_o(mode_w)
   );
   extirq_w1sc_reg #(.W(NCH), .RST('0)) u_pol (
      .clk(clk), .rst_n(rst_n), .set_en(wsel.pol_set), .clr_en(wsel.pol_clr),
      .bits_i(wbits), .q_o(pol_w)
   );
   extirq_w1sc_reg #(.W(NCH), .RST('0)) u_soft (
      .clk(clk), .rst_n(rst_n), .set_en(wsel.soft_set), .clr_en(wsel.soft_clr),
      .bits_i(wbits), .q_o(soft_w)
   );

   extirq_detect #(.NCH(NCH)) u_det (
      .clk(clk), .rst_n(rst_n), .now_i(pin_now), .prev_i(pin_prev),
      .mode_i(mode_w), .pol_i(pol_w), .soft_i(soft_w), .mask_i(mask_w),
      .ack_en(wsel.ack), .ack_bits(wbits),
      .hit_o(hit_w), .pend_o(pend_w), .status_o(status_w)
   );

   logic [NCH-1:0] rd_sel;
   always_comb begin
      rd_sel = '0;
      if      (at(addr, A_STATUS)) rd_sel = status_w;
      else if (at(addr, A_MASK))   rd_sel = mask_w;
      else if (at(addr, A_MODE))   rd_sel = mode_w;
      else if (at(addr, A_SOFT))   rd_sel = soft_w;
      else if (at(addr, A_POL))    rd_sel = pol_w;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= DATA_W'(rd_sel);
      else            rdata <= '0;
   end

   assign irq_o = |status_w;
endmodule

// File: rtl/extirq_bank_chk.sv
module extirq_bank_chk #(
   parameter int unsigned NCH    = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              irq_o,
   input logic [NCH-1:0]    mask_q,
   input logic [NCH-1:0]    pend_q,
   input logic [NCH-1:0]    hit_q
);
   import extirq_pkg::*;

   function automatic logic readable(input logic [ADDR_W-1:0] a);
      return a == ADDR_W'(A_STATUS) || a == ADDR_W'(A_MASK) || a == ADDR_W'(A_MODE) ||
             a == ADDR_W'(A_SOFT) || a == ADDR_W'(A_POL);
   endfunction

   // R2 / R10: masking everything silences the request line
   p_allmask_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(A_MASK_SET) && wdata[NCH-1:0] == {NCH{1'b1}}) |=> !irq_o);

   // R11: non-readable addresses return zero
   p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !readable(addr)) |=> (rdata == '0));

   // R5: a soft request on an unmasked channel raises the request line
   p_soft_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(A_SOFT_SET) && |(wdata[NCH-1:0] & ~mask_q)) |=> irq_o);

   // R6: a detected edge leaves its pending latch set
   p_edge_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit_q) |=> ((pend_q & $past(hit_q)) == $past(hit_q)));

   // R7: acknowledge clears latches that saw no new edge
   p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(A_ACK)) |=>
      ((pend_q & $past(wdata[NCH-1:0]) & ~$past(hit_q)) == '0));
endmodule

bind extirq_bank extirq_bank_chk #(.NCH(NCH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wdata(wdata), .rdata(rdata), .irq_o(irq_o),
   .mask_q(mask_w), .pend_q(pend_w), .hit_q(hit_w)
);

// File: tb/extirq_bank_bench.sv
`timescale 1ns/1ps
module extirq_bank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pin_i = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_o;

   always #2.5 clk = ~clk;

   extirq_bank u_extirq_bank (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
   );

   int n_chk = 0, n_err = 0;    // directed checks
   int m_chk = 0, m_err = 0;    // per-clock model comparison
   bit done = 0;

   // behavioural reference model
   logic [31:0] q_pin [$];
   logic [31:0] m_mask, m_mode, m_pol, m_soft, m_pend, m_rdata;

   function automatic logic [31:0] m_status();
      logic [31:0] r;
      logic [31:0] cur;
      cur = q_pin[1];
      for (int i = 0; i < 32; i++) begin
         logic act;
         if (m_mode[i]) act = (cur[i] == m_pol[i]);
         else           act = m_pend[i];
         r[i] = (act || m_soft[i]) && !m_mask[i];
      end
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         q_pin = '{32'h0, 32'h0, 32'h0};
         m_mask = '1; m_mode = '0; m_pol = '0; m_soft = '0; m_pend = '0; m_rdata = '0;
      end else begin
         logic [31:0] st, edges, nx_mask, nx_mode, nx_pol, nx_soft;
         st = m_status();
         if (rd_en) begin
            case (addr)
               12'h000: m_rdata = st;
               12'h080: m_rdata = m_mask;
               12'h140: m_rdata = m_mode;
               12'h200: m_rdata = m_soft;
               12'h300: m_rdata = m_pol;
               default: m_rdata = '0;
            endcase
         end else m_rdata = '0;
         for (int i = 0; i < 32; i++) begin
            logic a, b;
            a = q_pin[1][i]; b = q_pin[2][i];
            edges[i] = !m_mode[i] && (a != b) && (a == m_pol[i]);
         end
         if (wr_en && addr == 12'h040) m_pend = m_pend & ~wdata;
         m_pend = m_pend | edges;
         nx_mask = m_mask; nx_mode = m_mode; nx_pol = m_pol; nx_soft = m_soft;
         if (wr_en) begin
            case (addr)
               12'h0C0: nx_mask = m_mask | wdata;
               12'h100: nx_mask = m_mask & ~wdata;
               12'h180: nx_mode = m_mode | wdata;
               12'h1C0: nx_mode = m_mode & ~wdata;
               12'h240: nx_soft = m_soft | wdata;
               12'h280: nx_soft = m_soft & ~wdata;
               12'h340: nx_pol  = m_pol | wdata;
               12'h380: nx_pol  = m_pol & ~wdata;
               default: ;
            endcase
         end
         m_mask = nx_mask; m_mode = nx_mode; m_pol = nx_pol; m_soft = nx_soft;
         q_pin.push_front(pin_i);
         void'(q_pin.pop_back());
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         m_chk += 2;
         if (irq_o !== (|m_status())) begin
            m_err++;
            $display("FAIL R10 model irq: actual=%0b expected=%0b", irq_o, |m_status());
         end
         if (rdata !== m_rdata) begin
            m_err++;
            $display("FAIL R9 model rdata addr=%h: actual=%h expected=%h", addr, rdata, m_rdata);
         end
      end
   end

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err + m_err, n_chk + m_chk);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      wr_en = 1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 0; addr = '0; wdata = '0;
   endtask

   task automatic rd_bits(input logic [11:0] a, input logic [31:0] sel, input logic [31:0] exp, input string tag);
      rd_en = 1; addr = a;
      @(negedge clk);
      rd_en = 0; addr = '0;
      chk((rdata & sel) === exp, tag, rdata & sel, exp);
   endtask

   initial begin
      tick(3);
      rst_n = 1;
      tick(1);
      // R1 reset values
      chk(irq_o === 1'b0, "R1 irq", {31'b0, irq_o}, 0);
      rd_bits(12'h080, '1, 32'hFFFF_FFFF, "R1 mask");
      rd_bits(12'h140, '1, 0, "R1 mode");
      rd_bits(12'h300, '1, 0, "R1 pol");
      rd_bits(12'h200, '1, 0, "R1 soft");
      rd_bits(12'h000, '1, 0, "R1 status");
      // R2 alias writes
      wr(12'h100, 32'hF);
      rd_bits(12'h080, '1, 32'hFFFF_FFF0, "R2 mask clear");
      wr(12'h0C0, 32'h1);
      rd_bits(12'h080, '1, 32'hFFFF_FFF1, "R2 mask set keeps zeros");
      // R6 rising edge on ch2
      wr(12'h340, 32'h4);
      rd_bits(12'h300, '1, 32'h4, "R4 pol set");
      pin_i[2] = 1; tick(3);
      rd_bits(12'h000, 32'h4, 32'h4, "R6 edge latched");
      chk(irq_o === 1'b1, "R10 irq on", {31'b0, irq_o}, 1);
      pin_i[2] = 0; tick(3);
      rd_bits(12'h000, 32'h4, 32'h4, "R6 held after pin falls");
      wr(12'h040, 32'h4);
      rd_bits(12'h000, 32'h4, 0, "R7 ack clears");
      chk(irq_o === 1'b0, "R10 irq off", {31'b0, irq_o}, 0);
      // R8 level high ch3
      wr(12'h180, 32'h8); wr(12'h340, 32'h8);
      rd_bits(12'h140, '1, 32'h8, "R3 mode set");
      pin_i[3] = 1; tick(3);
      rd_bits(12'h000, 32'h8, 32'h8, "R8 level high active");
      wr(12'h040, 32'h8);
      rd_bits(12'h000, 32'h8, 32'h8, "R7 ack ignores level");
      pin_i[3] = 0; tick(3);
      rd_bits(12'h000, 32'h8, 0, "R8 level released");
      // R4 active-low level ch1
      wr(12'h180, 32'h2); tick(1);
      rd_bits(12'h000, 32'h2, 32'h2, "R4 low level active");
      wr(12'h340, 32'h2);
      rd_bits(12'h000, 32'h2, 0, "R4 high level idle");
      wr(12'h1C0, 32'h2);
      rd_bits(12'h140, '1, 32'h8, "R3 mode clear");
      // R5 soft request, R9 masking
      wr(12'h240, 32'h1);
      rd_bits(12'h000, 32'h1, 0, "R9 masked soft hidden");
      rd_bits(12'h200, '1, 32'h1, "R5 soft reads back");
      wr(12'h100, 32'h1);
      rd_bits(12'h000, 32'h1, 32'h1, "R5 soft visible");
      chk(irq_o === 1'b1, "R5 irq from soft", {31'b0, irq_o}, 1);
      wr(12'h040, 32'h1);
      rd_bits(12'h000, 32'h1, 32'h1, "R7 ack ignores soft");
      wr(12'h280, 32'h1);
      rd_bits(12'h000, 32'h1, 0, "R5 soft cleared");
      // R9 latch while masked
      wr(12'h340, 32'h20);
      pin_i[5] = 1; tick(3);
      rd_bits(12'h000, 32'h20, 0, "R9 masked latch hidden");
      pin_i[5] = 0;
      wr(12'h100, 32'h20);
      rd_bits(12'h000, 32'h20, 32'h20, "R9 latch shown on unmask");
      wr(12'h040, 32'h20);
      // R7 ack collides with a fresh edge on ch6
      wr(12'h100, 32'h40); wr(12'h340, 32'h40);
      pin_i[6] = 1; tick(3);
      rd_bits(12'h000, 32'h40, 32'h40, "R6 ch6 latched");
      pin_i[6] = 0; tick(3);
      pin_i[6] = 1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      wr(12'h040, 32'h40);
      rd_bits(12'h000, 32'h40, 32'h40, "R7 edge wins over ack");
      wr(12'h040, 32'h40);
      rd_bits(12'h000, 32'h40, 0, "R7 later ack clears");
      // R11 decode
      rd_bits(12'h010, '1, 0, "R11 unmapped reads zero");
      rd_bits(12'h040, '1, 0, "R11 ack reads zero");
      wr(12'h080, 32'h0);
      rd_bits(12'h080, 32'hFF, 32'h90, "R11 read-only write ignored");
      wr(12'h0C0, 32'hFFFF_FFFF); tick(1);
      chk(irq_o === 1'b0, "R2 all masked", {31'b0, irq_o}, 0);
      // random phase, checked by the model every clock
      for (int k = 0; k < 2000; k++) begin
         logic [11:0] alist [14];
         alist = '{12'h000, 12'h040, 12'h080, 12'h0C0, 12'h100, 12'h140, 12'h180,
                   12'h1C0, 12'h200, 12'h240, 12'h280, 12'h300, 12'h340, 12'h380};
         if ($urandom_range(3) == 0) pin_i = pin_i ^ (32'h1 << $urandom_range(31));
         wr_en = ($urandom_range(2) == 0);
         rd_en = ($urandom_range(1) == 0);
         addr  = alist[$urandom_range(13)];
         wdata = $urandom() & $urandom();
         @(negedge clk);
      end
      wr_en = 0; rd_en = 0;
      tick(2);
      finish_run();
   end
endmodule